// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Unit

This block gathers four interrupt events of a USB host controller into one level interrupt line: device resume seen on the bus, frame start, completion of a done-queue writeback to shared memory, and a schedule overrun within a frame. Each event is a one-cycle input pulse. It latches a sticky status bit, and software clears that bit by writing a one to it. A per-source enable register, gated by a master enable, decides which latched bits reach the interrupt pin. The enable register is changed only through a set address and a clear address, so writing zeros never disturbs bits that other software owns.

The unit also controls the done-queue writeback. A small state machine issues a one-cycle writeback strobe for each request. It then sets the writeback-done status bit and refuses further writebacks until software has cleared that bit, so the shared done-head word is never overwritten before it is consumed. A request that arrives while the bit is set is held and is issued right after the clearing write. A 2-bit counter records overrun events, and a start-of-frame token request is emitted in the cycle the frame-start bit appears.

Writeback state machine (`wb_state_t`): `WB_IDLE` (no request, done bit clear), `WB_WRITE` (strobe cycle), `WB_HOLD` (done bit set, nothing waiting), `WB_PEND` (done bit set, one request waiting). Transitions: IDLE→WRITE on request; WRITE→PEND on request, otherwise WRITE→HOLD; HOLD→WRITE on a clear together with a request, HOLD→IDLE on a clear alone, HOLD→PEND on a request alone; PEND→WRITE on a clear.

Top module: `usbh_irq_unit`

## Requirements
- R1: After reset all status bits, all enable bits, the master enable and the overrun counter are 0, and `irq`, `wb_strobe` and `sof_token_req` are low.
- R2: A pulse on an event input sets its status bit at the next clock edge. The status word read at address 0 holds: bit 3 resume, bit 2 frame start, bit 1 writeback done, bit 0 overrun. All other bits read 0.
- R3: Writing to address 0 clears each status bit whose data bit is 1 and leaves the others alone. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Writing to address 1 sets each enable bit (data bits 3:0) and the master enable (data bit 31) where the data is 1, and a 0 leaves that bit unchanged. Writing to address 2 clears each of these bits where the data is 1. Reading address 1 or 2 returns the enables in bits 3:0 and the master enable in bit 31.
- R5: `irq` is high exactly when some status bit and its enable bit are both 1 and the master enable is 1.
- R6: `sof_token_req` is high for one cycle, in the cycle after an `ev_sof` pulse, which is the same cycle in which status bit 2 is first seen set.
- R7: A writeback request while idle gives `wb_strobe` high for exactly one cycle, in the cycle after the request. Status bit 1 is set in the cycle after the strobe.
- R8: `wb_strobe` never goes high while status bit 1 is set. A request made while the bit is set is issued as a strobe in the cycle right after the write that clears it.
- R9: Each `ev_overrun` pulse increments a 2-bit counter that wraps from 3 to 0. It reads at address 3 in bits 1:0, and the other bits read 0.
- R10: A resume pulse has no effect on status bit 3 while `sw_resume_active` is high.
- R11: Several requests that arrive while status bit 1 is set produce only one strobe after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable set, 2 enable clear, 3 counter) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_resume | input | 1 | Downstream device resume seen |
| ev_sof | input | 1 | Frame started, frame number already updated |
| ev_overrun | input | 1 | Schedule overran in current frame |
| sw_resume_active | input | 1 | Software is driving resume on the bus |
| wb_req | input | 1 | Done-head writeback requested |
| wb_strobe | output | 1 | Done-head writeback issued (one cycle) |
| sof_token_req | output | 1 | Start-of-frame token request |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a writeback request that lands in the very cycle of the clearing write. The same is true of several requests piled up in `WB_PEND`, and of a set that collides with its own clear. Random traffic reaches these only rarely, so the bench forces each of them with a directed sequence. After that it runs a long random phase with frequent requests and status writes, compared every cycle against a cycle-level model of the requirements.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_OVR  = 0;
    localparam int SRC_WBD  = 1;
    localparam int SRC_SOF  = 2;
    localparam int SRC_RSM  = 3;

    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] REG_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] REG_EN_SET = 2'd1;
    localparam logic [ADDR_W-1:0] REG_EN_CLR = 2'd2;
    localparam logic [ADDR_W-1:0] REG_OVR_CNT = 2'd3;

    typedef enum logic [1:0] {
        WB_IDLE  = 2'd0,
        WB_WRITE = 2'd1,
        WB_HOLD  = 2'd2,
        WB_PEND  = 2'd3
    } wb_state_t;

endpackage

// File: rtl/usbh_irq_status.sv
module usbh_irq_status #(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    input  logic               ovr_evt,
    output logic [NUM_SRC-1:0] status_q,
    output logic [CNT_W-1:0]   ovr_cnt_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status_q[i] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> status_q[i]);                               // R3
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);             // R3
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !clr_vec[i]) |=> status_q[i]);             // R2
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_cnt_q <= '0;
        end else if (ovr_evt) begin
            ovr_cnt_q <= ovr_cnt_q + CNT_ONE;
        end
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && ovr_cnt_q == CNT_TOP) |=> (ovr_cnt_q == '0));      // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_evt |=> $stable(ovr_cnt_q));                              // R9

endmodule

// File: rtl/usbh_irq_enable.sv
module usbh_irq_enable #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] wr_bits,
    input  logic               wr_master,
    output logic [NUM_SRC-1:0] en_q,
    output logic               mie_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (set_we && wr_bits[i]) begin
                en_q[i] <= 1'b1;
            end else if (clr_we && wr_bits[i]) begin
                en_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie_q <= 1'b0;
        end else if (set_we && wr_master) begin
            mie_q <= 1'b1;
        end else if (clr_we && wr_master) begin
            mie_q <= 1'b0;
        end
    end

    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(en_q)) == $past(en_q)));              // R4
    AST_SET_KEEPS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && mie_q) |=> mie_q);                                  // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> ($stable(en_q) && $stable(mie_q)));   // R4

endmodule

// File: rtl/usbh_irq_wb_fsm.sv
module usbh_irq_wb_fsm
    import usbh_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wb_req,
    input  logic done_clr,
    output logic wb_strobe,
    output logic done_set
);

    wb_state_t state_q;
    wb_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_IDLE: begin
                if (wb_req) state_d = WB_WRITE;
            end
            WB_WRITE: begin
                state_d = wb_req ? WB_PEND : WB_HOLD;
            end
            WB_HOLD: begin
                if (done_clr) state_d = wb_req ? WB_WRITE : WB_IDLE;
                else if (wb_req) state_d = WB_PEND;
            end
            WB_PEND: begin
                if (done_clr) state_d = WB_WRITE;
            end
            default: state_d = WB_IDLE;
        endcase
    end

    always_comb begin
        wb_strobe = 1'b0;
        done_set  = 1'b0;
        unique case (state_q)
            WB_WRITE: begin
                wb_strobe = 1'b1;
                done_set  = 1'b1;
            end
            WB_IDLE, WB_HOLD, WB_PEND: begin
                wb_strobe = 1'b0;
                done_set  = 1'b0;
            end
            default: begin
                wb_strobe = 1'b0;
                done_set  = 1'b0;
            end
        endcase
    end

    AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WB_PEND && !done_clr) |=> (state_q == WB_PEND));   // R11
    AST_PEND_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WB_PEND && done_clr) |=> wb_strobe);               // R8

endmodule

// File: rtl/usbh_irq_unit.sv
module usbh_irq_unit
    import usbh_irq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 2,
    parameter int MIE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_resume,
    input  logic              ev_sof,
    input  logic              ev_overrun,
    input  logic              sw_resume_active,
    input  logic              wb_req,
    output logic              wb_strobe,
    output logic              sof_token_req,
    output logic              irq
);

    logic               wr_status;
    logic               wr_en_set;
    logic               wr_en_clr;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] en_q;
    logic               mie_q;
    logic [CNT_W-1:0]   ovr_cnt_q;
    logic               done_set;
    logic               done_clr;
    logic               sof_q;

    assign wr_status = reg_wr && (reg_addr == REG_STATUS);
    assign wr_en_set = reg_wr && (reg_addr == REG_EN_SET);
    assign wr_en_clr = reg_wr && (reg_addr == REG_EN_CLR);
    assign clr_vec   = wr_status ? reg_wdata[NUM_SRC-1:0] : '0;
    assign done_clr  = clr_vec[SRC_WBD];

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_OVR] = ev_overrun;
        set_vec[SRC_WBD] = done_set;
        set_vec[SRC_SOF] = ev_sof;
        set_vec[SRC_RSM] = ev_resume && !sw_resume_active;
    end

    usbh_irq_wb_fsm u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_req    (wb_req),
        .done_clr  (done_clr),
        .wb_strobe (wb_strobe),
        .done_set  (done_set)
    );

    usbh_irq_status #(
        .NUM_SRC (NUM_SRC),
        .CNT_W   (CNT_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .ovr_evt   (ev_overrun),
        .status_q  (status_q),
        .ovr_cnt_q (ovr_cnt_q)
    );

    usbh_irq_enable #(
        .NUM_SRC (NUM_SRC)
    ) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (wr_en_set),
        .clr_we    (wr_en_clr),
        .wr_bits   (reg_wdata[NUM_SRC-1:0]),
        .wr_master (reg_wdata[MIE_BIT]),
        .en_q      (en_q),
        .mie_q     (mie_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_q <= 1'b0;
        end else begin
            sof_q <= ev_sof;
        end
    end

    assign sof_token_req = sof_q;
    assign irq           = mie_q && |(status_q & en_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_STATUS:  reg_rdata[NUM_SRC-1:0] = status_q;
            REG_EN_SET,
            REG_EN_CLR: begin
                reg_rdata[NUM_SRC-1:0] = en_q;
                reg_rdata[MIE_BIT]     = mie_q;
            end
            REG_OVR_CNT: reg_rdata[CNT_W-1:0] = ovr_cnt_q;
            default:     reg_rdata = '0;
        endcase
    end

    AST_NO_WB_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_strobe |-> !status_q[SRC_WBD]);                             // R8
    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_strobe |=> status_q[SRC_WBD]);                              // R7
    AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_strobe |=> !wb_strobe);                                     // R7
    AST_SOF_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sof_token_req |-> status_q[SRC_SOF]);                          // R6
    AST_RESUME_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_resume_active && !status_q[SRC_RSM]) |=> !status_q[SRC_RSM]); // R10
    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mie_q);                                                // R5

endmodule

// File: tb/usbh_irq_unit_tb.sv
module usbh_irq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        ev_resume = 1'b0;
    logic        ev_sof = 1'b0;
    logic        ev_overrun = 1'b0;
    logic        sw_resume_active = 1'b0;
    logic        wb_req = 1'b0;
    logic        wb_strobe;
    logic        sof_token_req;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 0;

    logic [3:0] m_st;
    logic [3:0] m_en;
    logic       m_mie;
    logic [1:0] m_cnt;
    int         m_wb;    // 0 idle, 1 write, 2 hold, 3 pend
    logic       m_sof;

    always #5 clk = ~clk;

    usbh_irq_unit u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_wr           (reg_wr),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .ev_resume        (ev_resume),
        .ev_sof           (ev_sof),
        .ev_overrun       (ev_overrun),
        .sw_resume_active (sw_resume_active),
        .wb_req           (wb_req),
        .wb_strobe        (wb_strobe),
        .sof_token_req    (sof_token_req),
        .irq              (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {28'd0, m_st};
            2'd1, 2'd2: return {m_mie, 27'd0, m_en};
            default: return {30'd0, m_cnt};
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_mie && |(m_st & m_en);
    endfunction

    task automatic model_edge();
        logic [3:0] clr;
        logic [3:0] set;
        logic       dclr;
        clr  = (reg_wr && reg_addr == 2'd0) ? reg_wdata[3:0] : 4'd0;
        dclr = clr[1];
        set  = {ev_resume && !sw_resume_active, ev_sof, m_wb == 1, ev_overrun};
        m_st = (m_st & ~clr) | set;
        if (reg_wr && reg_addr == 2'd1) begin
            m_en  = m_en | reg_wdata[3:0];
            m_mie = m_mie | reg_wdata[31];
        end else if (reg_wr && reg_addr == 2'd2) begin
            m_en  = m_en & ~reg_wdata[3:0];
            m_mie = m_mie & ~reg_wdata[31];
        end
        if (ev_overrun) m_cnt = m_cnt + 2'd1;
        m_sof = ev_sof;
        case (m_wb)
            0: m_wb = wb_req ? 1 : 0;
            1: m_wb = wb_req ? 3 : 2;
            2: m_wb = dclr ? (wb_req ? 1 : 0) : (wb_req ? 3 : 2);
            default: m_wb = dclr ? 1 : 3;
        endcase
    endtask

    task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                        input logic rsm, input logic sof, input logic ovr,
                        input logic req, input logic swr);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        ev_resume = rsm; ev_sof = sof; ev_overrun = ovr;
        wb_req = req; sw_resume_active = swr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R5 irq", {31'd0, irq}, {31'd0, exp_irq()});
        chk("R7/R8 wb_strobe", {31'd0, wb_strobe}, {31'd0, (m_wb == 1)});
        chk("R6 sof_token_req", {31'd0, sof_token_req}, {31'd0, m_sof});
        chk(a == 2'd0 ? "R2 status read" : (a == 2'd3 ? "R9 counter read" : "R4 enable read"),
            reg_rdata, exp_read(a));
        reg_wr = 1'b0; ev_resume = 1'b0; ev_sof = 1'b0; ev_overrun = 1'b0; wb_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 2'd0, 32'd0, 0, 0, 0, 0, 0);
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [31:0] r;
        logic [1:0] cnt0;
        seed = 32'h1234abcd;
        void'($urandom(seed));
        m_st = 0; m_en = 0; m_mie = 0; m_cnt = 0; m_wb = 0; m_sof = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 wb_strobe", {31'd0, wb_strobe}, 32'd0);
        chk("R1 sof_token_req", {31'd0, sof_token_req}, 32'd0);
        for (int a = 0; a < 4; a++) read_chk("R1 register read", a[1:0], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: set, write-zero no effect, clear
        step(1, 2'd1, 32'h8000_0005, 0, 0, 0, 0, 0);
        read_chk("R4 enable after set", 2'd1, 32'h8000_0005);
        step(1, 2'd1, 32'h0000_0000, 0, 0, 0, 0, 0);
        read_chk("R4 write zero keeps enables", 2'd1, 32'h8000_0005);
        step(1, 2'd2, 32'h0000_0001, 0, 0, 0, 0, 0);
        read_chk("R4 clear address", 2'd2, 32'h8000_0004);

        // R2/R5: frame start raises status bit 2 and irq (enable bit 2 set)
        step(0, 2'd0, 32'd0, 0, 1, 0, 0, 0);
        read_chk("R2 sof bit position", 2'd0, 32'h0000_0004);
        chk("R6 token with bit", {31'd0, sof_token_req}, 32'd1);
        chk("R5 irq asserted", {31'd0, irq}, 32'd1);

        // R3: set beats clear in the same cycle
        step(1, 2'd0, 32'h0000_0004, 0, 1, 0, 0, 0);
        read_chk("R3 set wins over clear", 2'd0, 32'h0000_0004);
        step(1, 2'd0, 32'h0000_0004, 0, 0, 0, 0, 0);
        read_chk("R3 clear by one", 2'd0, 32'h0000_0000);
        chk("R5 irq released", {31'd0, irq}, 32'd0);

        // R10: resume ignored while software drives resume
        step(0, 2'd0, 32'd0, 1, 0, 0, 0, 1);
        read_chk("R10 resume masked", 2'd0, 32'h0000_0000);
        step(0, 2'd0, 32'd0, 1, 0, 0, 0, 0);
        read_chk("R2 resume bit position", 2'd0, 32'h0000_0008);
        step(1, 2'd0, 32'h0000_0008, 0, 0, 0, 0, 0);

        // R9: four overruns wrap the counter back to its start
        read_chk("R9 counter start", 2'd3, {30'd0, m_cnt});
        cnt0 = m_cnt;
        for (int k = 0; k < 4; k++) step(0, 2'd3, 32'd0, 0, 0, 1, 0, 0);
        read_chk("R9 counter wrap", 2'd3, {30'd0, cnt0});
        read_chk("R2 overrun bit position", 2'd0, 32'h0000_0001);
        step(1, 2'd0, 32'h0000_0001, 0, 0, 0, 0, 0);

        // R7: request from idle
        step(0, 2'd0, 32'd0, 0, 0, 0, 1, 0);
        chk("R7 strobe after request", {31'd0, wb_strobe}, 32'd1);
        step(0, 2'd0, 32'd0, 0, 0, 0, 0, 0);
        chk("R7 strobe one cycle", {31'd0, wb_strobe}, 32'd0);
        read_chk("R7 done bit set", 2'd0, 32'h0000_0002);

        // R8/R11: requests held while done set, one strobe after clear
        step(0, 2'd0, 32'd0, 0, 0, 0, 1, 0);
        step(0, 2'd0, 32'd0, 0, 0, 0, 1, 0);
        chk("R8 no strobe while done", {31'd0, wb_strobe}, 32'd0);
        idle(2);
        step(1, 2'd0, 32'h0000_0002, 0, 0, 0, 0, 0);
        chk("R8 strobe after clear", {31'd0, wb_strobe}, 32'd1);
        step(1, 2'd0, 32'h0000_0002, 0, 0, 0, 0, 0);
        chk("R11 single strobe", {31'd0, wb_strobe}, 32'd0);
        read_chk("R3 set wins for done bit", 2'd0, 32'h0000_0002);
        // clear together with a new request: strobe next cycle
        step(1, 2'd0, 32'h0000_0002, 0, 0, 0, 1, 0);
        chk("R8 clear with request", {31'd0, wb_strobe}, 32'd1);
        step(1, 2'd0, 32'h0000_0002, 0, 0, 0, 0, 0);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic wr;
            logic [1:0] a;
            r = $urandom;
            wr = ($urandom % 4) == 0;
            a = 2'($urandom % 4);
            step(wr, a, {r[31], r[30:4] & 27'h0, r[3:0]},
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom % 5) == 0, ($urandom % 4) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule